// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous SRAM

This block is a single-clock synchronous static memory with a pipelined read path. Every access input is caught in an input register on the rising clock edge. These inputs are the address, the write word, the three chip selects, the write controls and the doze request. On the following edge the registered request does one of three things. It writes the array, or it reads the array into an output register, or it does nothing. The word is split into byte lanes. Each lane is eight data bits plus one extra check bit, nine bits in all, and the lane count is a parameter.

Writes follow one of two paths. A whole-word write strobe writes every lane and ignores the lane controls. A lane-write enable writes only the lanes whose individual lane strobes are set. A selected access that is not a write is a read. Read data and a data-valid flag come out of output registers one clock after the request is registered. An asynchronous output enable gates the flag and the data bus, in the manner of a tri-state drive. Burst address generation belongs to a separate sequencer that drives `addr_i`.

Top module: `pipe_sram`

## Requirements
- R1: A read captured at rising edge N has its word on `q_o` with `q_drive_o` high after edge N+1, provided `out_en_i` is high. A read is a selected access in which `all_wr_i` is 0 and no lane is write-enabled.
- R2: With `all_wr_i` = 1, a selected access writes every lane of `addr_i`, whatever `lane_wr_en_i` and `lane_sel_i` hold.
- R3: With `all_wr_i` = 0 and `lane_wr_en_i` = 1, only the lanes with a set bit in `lane_sel_i` are written. Bit i selects lane i, which is `wdata_i[9i+8:9i]`. Lanes whose bit is clear keep their contents.
- R4: With `all_wr_i` = 0, the access is a read and leaves the array unchanged when `lane_wr_en_i` is 0, or when `lane_wr_en_i` is 1 and `lane_sel_i` is all zero.
- R5: An access is selected only when `sel0_n_i` = 0, `sel1_i` = 1 and `sel2_n_i` = 0. An unselected access writes nothing, and the cycle after its following edge shows `q_drive_o` = 0.
- R6: A lane write to an address followed in the very next cycle by a read of that address returns the new lanes and the old values of the unwritten lanes.
- R7: `out_en_i` acts without a clock. When it is 0, or when no valid read word is held, `q_drive_o` is 0 and `q_o` is all zero.
- R8: An access captured while `doze_i` = 1 is ignored. It writes nothing, and after the next edge `q_drive_o` = 0.
- R9: Synchronous active-high `rst` clears the data-valid flag, so `q_drive_o` = 0 and `q_o` = 0 during and after reset until a read completes.
- R10: A write access gives `q_drive_o` = 0 in its output cycle and leaves the output word register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| doze_i | input | 1 | Low-power standby request; accesses are ignored while high |
| sel0_n_i | input | 1 | Chip select, active low |
| sel1_i | input | 1 | Chip select, active high |
| sel2_n_i | input | 1 | Chip select, active low |
| addr_i | input | AW (8) | Word address |
| wdata_i | input | LANES*LANE_W (36) | Write word, lane i at bits 9i+8..9i |
| all_wr_i | input | 1 | Whole-word write strobe, active high |
| lane_wr_en_i | input | 1 | Lane-write enable, active high |
| lane_sel_i | input | LANES (4) | Per-lane write strobes, active high |
| out_en_i | input | 1 | Asynchronous output enable, active high |
| q_o | output | LANES*LANE_W (36) | Read word, zero while not driven |
| q_drive_o | output | 1 | Read word valid and driven |

## Verification
A lane mask decoded wrongly in the input stage does not show at the ports when it happens. It shows only when the same address is read later, as a corrupted or stale lane. For this reason every address is preloaded and random traffic re-reads addresses it has written. A wrong operation code or valid register shows two clock edges after the access is driven, as a drive flag that is set when it should not be, or missing when it should be set. The bench compares that flag on every cycle. An output-enable fault shows in the same cycle that the enable changes.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;
endpackage

// File: rtl/sram_req_reg.sv
module sram_req_reg
  import sram_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter int W     = 36
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             doze_i,
  input  logic             sel0_n_i,
  input  logic             sel1_i,
  input  logic             sel2_n_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             all_wr_i,
  input  logic             lane_wr_en_i,
  input  logic [LANES-1:0] lane_sel_i,
  output sram_op_e         op_q,
  output logic [AW-1:0]    addr_q,
  output logic [W-1:0]     wdata_q,
  output logic [LANES-1:0] mask_q
);
  logic             picked;
  logic [LANES-1:0] mask_d;
  sram_op_e         op_d;

  // whole-word strobe wins over the lane path
  always_comb begin
    picked = !sel0_n_i && sel1_i && !sel2_n_i && !doze_i;
    if (all_wr_i)          mask_d = '1;
    else if (lane_wr_en_i) mask_d = lane_sel_i;
    else                   mask_d = '0;
    if (!picked)           op_d = OP_IDLE;
    else if (|mask_d)      op_d = OP_WRITE;
    else                   op_d = OP_READ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= OP_IDLE;
      mask_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      op_q    <= op_d;
      mask_q  <= picked ? mask_d : '0;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end
endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
  parameter int AW     = 8,
  parameter int LANE_W = 9,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [AW-1:0]     addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rd_q
);
  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // output register of the RAM, doubles as the pipeline stage
  always_ff @(posedge clk) begin
    if (rst)     rd_q <= '0;
    else if (re) rd_q <= mem[addr];
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_op,
  input  logic [W-1:0] rd_word,
  input  logic         out_en_i,
  output logic         vld_q,
  output logic [W-1:0] q_o,
  output logic         q_drive_o
);
  // a non-read cycle clears the flag after one edge
  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= rd_op;
  end

  always_comb begin
    q_drive_o = vld_q && out_en_i;
    q_o       = q_drive_o ? rd_word : '0;
  end
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import sram_pkg::*;
#(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int W     = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             doze_i,
  input  logic             sel0_n_i,
  input  logic             sel1_i,
  input  logic             sel2_n_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             all_wr_i,
  input  logic             lane_wr_en_i,
  input  logic [LANES-1:0] lane_sel_i,
  input  logic             out_en_i,
  output logic [W-1:0]     q_o,
  output logic             q_drive_o
);
  sram_op_e         op_q;
  logic [AW-1:0]    addr_q;
  logic [W-1:0]     wdata_q;
  logic [LANES-1:0] mask_q;
  logic [W-1:0]     rd_word;
  logic             vld_q;
  logic             rd_op;

  sram_req_reg #(.AW(AW), .LANES(LANES), .W(W)) u_req (
    .clk(clk), .rst(rst), .doze_i(doze_i),
    .sel0_n_i(sel0_n_i), .sel1_i(sel1_i), .sel2_n_i(sel2_n_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .all_wr_i(all_wr_i),
    .lane_wr_en_i(lane_wr_en_i), .lane_sel_i(lane_sel_i),
    .op_q(op_q), .addr_q(addr_q), .wdata_q(wdata_q), .mask_q(mask_q)
  );

  assign rd_op = (op_q == OP_READ);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_lane_bank #(.AW(AW), .LANE_W(LANE_W)) u_bank (
      .clk(clk), .rst(rst),
      .we((op_q == OP_WRITE) && mask_q[g]),
      .re(rd_op),
      .addr(addr_q),
      .wdata(wdata_q[g*LANE_W +: LANE_W]),
      .rd_q(rd_word[g*LANE_W +: LANE_W])
    );
  end

  sram_out_stage #(.W(W)) u_out (
    .clk(clk), .rst(rst), .rd_op(rd_op), .rd_word(rd_word),
    .out_en_i(out_en_i), .vld_q(vld_q), .q_o(q_o), .q_drive_o(q_drive_o)
  );
endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk #(
  parameter int LANES = 4,
  parameter int W     = 36
) (
  input logic             clk,
  input logic             rst,
  input logic             doze_i,
  input logic             sel0_n_i,
  input logic             sel1_i,
  input logic             sel2_n_i,
  input logic             all_wr_i,
  input logic             lane_wr_en_i,
  input logic [LANES-1:0] lane_sel_i,
  input logic             vld_q,
  input logic [W-1:0]     rd_word
);
  logic sel_in;
  logic wr_in;
  assign sel_in = !sel0_n_i && sel1_i && !sel2_n_i;
  assign wr_in  = all_wr_i || (lane_wr_en_i && (|lane_sel_i));

  AST_READ_VALID: assert property (@(posedge clk) disable iff (rst)
    (sel_in && !doze_i && !wr_in) |-> ##2 vld_q); // R1
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !sel_in |-> ##2 !vld_q); // R5
  AST_DOZE_QUIET: assert property (@(posedge clk) disable iff (rst)
    doze_i |-> ##2 !vld_q); // R8
  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sel_in && !doze_i && wr_in) |-> ##2 (!vld_q && $stable(rd_word))); // R10
endmodule

bind pipe_sram pipe_sram_chk #(.LANES(LANES), .W(W)) u_chk (
  .clk(clk), .rst(rst), .doze_i(doze_i),
  .sel0_n_i(sel0_n_i), .sel1_i(sel1_i), .sel2_n_i(sel2_n_i),
  .all_wr_i(all_wr_i), .lane_wr_en_i(lane_wr_en_i), .lane_sel_i(lane_sel_i),
  .vld_q(vld_q), .rd_word(rd_word)
);

// File: tb/pipe_sram_test.sv
module pipe_sram_test;
  localparam int AW = 8, LANES = 4, LW = 9, W = LANES * LW, DEPTH = 1 << AW;

  logic clk = 1'b0, rst = 1'b1;
  logic doze_i = 0, sel0_n_i = 1, sel1_i = 0, sel2_n_i = 1;
  logic [AW-1:0] addr_i = '0;
  logic [W-1:0] wdata_i = '0;
  logic all_wr_i = 0, lane_wr_en_i = 0;
  logic [LANES-1:0] lane_sel_i = '0;
  logic out_en_i = 1;
  logic [W-1:0] q_o;
  logic q_drive_o;

  int n_chk = 0, n_bad = 0;
  logic [W-1:0] model [DEPTH];
  bit ev [2];
  logic [W-1:0] ed [2];
  string et [2];

  pipe_sram #(.AW(AW), .LANES(LANES), .LANE_W(LW)) uut (
    .clk(clk), .rst(rst), .doze_i(doze_i),
    .sel0_n_i(sel0_n_i), .sel1_i(sel1_i), .sel2_n_i(sel2_n_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .all_wr_i(all_wr_i),
    .lane_wr_en_i(lane_wr_en_i), .lane_sel_i(lane_sel_i),
    .out_en_i(out_en_i), .q_o(q_o), .q_drive_o(q_drive_o)
  );

  always #10 clk = ~clk;

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic logic [W-1:0] rnd_word();
    logic [W-1:0] r = '0;
    for (int i = 0; i < W; i++) r[i] = 1'($urandom);
    return r;
  endfunction

  function automatic logic [W-1:0] merge(logic [W-1:0] old_w, logic [W-1:0] new_w,
                                         logic [LANES-1:0] m);
    logic [W-1:0] r = old_w;
    for (int i = 0; i < LANES; i++)
      if (m[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
    return r;
  endfunction

  task automatic cmp(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input bit s0n, input bit s1, input bit s2n, input bit dz,
                      input bit aw, input bit lwe, input logic [LANES-1:0] ls,
                      input logic [AW-1:0] a, input logic [W-1:0] d, input bit oe,
                      input string tag);
    bit sel, nv;
    logic [LANES-1:0] m;
    logic [W-1:0] nd;
    @(negedge clk);
    sel0_n_i = s0n; sel1_i = s1; sel2_n_i = s2n; doze_i = dz;
    all_wr_i = aw; lane_wr_en_i = lwe; lane_sel_i = ls;
    addr_i = a; wdata_i = d; out_en_i = oe;
    sel = !s0n && s1 && !s2n && !dz;
    m = aw ? '1 : (lwe ? ls : '0);
    nv = 0; nd = '0;
    if (sel) begin
      if (|m) model[a] = merge(model[a], d, m);
      else begin nv = 1; nd = model[a]; end
    end
    #1;
    // output now reflects the access driven two steps earlier
    cmp({et[1], " drive"}, W'(q_drive_o), W'(ev[1] && oe));
    cmp({et[1], " data"}, q_o, (ev[1] && oe) ? ed[1] : '0);
    ev[1] = ev[0]; ed[1] = ed[0]; et[1] = et[0];
    ev[0] = nv;    ed[0] = nd;    et[0] = tag;
  endtask

  task automatic rd(input logic [AW-1:0] a, input bit oe, input string tag);
    step(0, 1, 0, 0, 0, 0, '0, a, rnd_word(), oe, tag);
  endtask

  initial begin
    logic [W-1:0] keep;
    void'($urandom(32'h5A17_C0DE));
    ev[0] = 0; ev[1] = 0; ed[0] = '0; ed[1] = '0; et[0] = "R9"; et[1] = "R9";
    repeat (3) @(negedge clk);
    cmp("R9 drive in reset", W'(q_drive_o), '0);
    cmp("R9 data in reset", q_o, '0);
    @(negedge clk); rst = 0;

    // preload every word through the whole-word path
    for (int i = 0; i < DEPTH; i++)
      step(0, 1, 0, 0, 1, 0, '0, AW'(i), rnd_word(), 1, "R2");

    rd(8'd5, 1, "R1");                                     // R1 plain read
    step(0, 1, 0, 0, 0, 1, 4'b0101, 8'd9, rnd_word(), 1, "R3");
    rd(8'd9, 1, "R6");                                     // R6 back-to-back merge
    step(0, 1, 0, 0, 1, 0, 4'b0000, 8'd10, rnd_word(), 1, "R2");
    rd(8'd10, 1, "R2");                                    // R2 ignores lane controls
    step(0, 1, 0, 0, 0, 1, 4'b1000, 8'd11, rnd_word(), 1, "R3");
    rd(8'd11, 1, "R3");
    step(0, 1, 0, 0, 0, 1, 4'b0000, 8'd11, rnd_word(), 1, "R4"); // R4 empty strobes read
    step(0, 1, 0, 0, 0, 0, 4'b1111, 8'd11, rnd_word(), 1, "R4"); // R4 strobes alone read
    rd(8'd11, 1, "R4");
    // R5 each select inactive in turn, with a write that must be dropped
    step(1, 1, 0, 0, 1, 0, '0, 8'd20, rnd_word(), 1, "R5");
    step(0, 0, 0, 0, 1, 0, '0, 8'd20, rnd_word(), 1, "R5");
    step(0, 1, 1, 0, 1, 0, '0, 8'd20, rnd_word(), 1, "R5");
    step(0, 0, 0, 0, 0, 0, '0, 8'd20, rnd_word(), 1, "R5");
    rd(8'd20, 1, "R5");
    // R8 doze drops write and read
    step(0, 1, 0, 1, 1, 0, '0, 8'd21, rnd_word(), 1, "R8");
    step(0, 1, 0, 1, 0, 0, '0, 8'd21, rnd_word(), 1, "R8");
    rd(8'd21, 1, "R8");
    // R7 output enable low at the output cycle hides a valid word
    rd(8'd30, 1, "R7");
    rd(8'd31, 1, "R7");
    rd(8'd32, 0, "R7");
    rd(8'd33, 1, "R7");
    // R10 write then read of a different address
    step(0, 1, 0, 0, 0, 1, 4'b0010, 8'd40, rnd_word(), 1, "R10");
    rd(8'd41, 1, "R10");

    for (int k = 0; k < 4000; k++) begin
      bit s0n, s1, s2n, dz, aw, lwe, oe;
      s0n = ($urandom % 10) == 0;
      s1  = ($urandom % 10) != 0;
      s2n = ($urandom % 10) == 0;
      dz  = ($urandom % 16) == 0;
      aw  = ($urandom % 8) == 0;
      lwe = ($urandom % 3) == 0;
      oe  = ($urandom % 8) != 0;
      step(s0n, s1, s2n, dz, aw, lwe, LANES'($urandom), AW'($urandom % 16),
           rnd_word(), oe, "R1");
    end
    step(0, 0, 0, 0, 0, 0, '0, '0, '0, 1, "R5");
    step(0, 0, 0, 0, 0, 0, '0, '0, '0, 1, "R5");
    step(0, 0, 0, 0, 0, 0, '0, '0, '0, 1, "R5");

    // R9 reset mid-stream clears the flag
    rd(8'd3, 1, "R9");
    @(negedge clk); rst = 1;
    @(negedge clk); #1;
    cmp("R9 drive after reset", W'(q_drive_o), '0);
    keep = q_o;
    cmp("R9 data after reset", keep, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule